// File: doc/BRIEF.md
# Programmable input glitch filter

This block cleans up a raw digital input before it reaches a timer channel's edge logic. The input is first synchronized into the clock domain. The synchronized level then reaches the filtered output only when it has held its new value for a programmed number of sampling edges. Shorter pulses are discarded. Sampling edges are either every clock, or single-cycle enable pulses from a global divider followed by a per-channel divider.

A 4-bit latency code selects the minimum width. The filtered level can be read at any time. An edge detector on the filtered level sets a sticky flag on rising or falling transitions, as chosen by a polarity input, and a one-cycle clear pulse resets the flag.

Top module: `glitch_filter`

## Requirements
- R1: During and right after reset, `level` and `edge_flag` are 0.
- R2: `pin_in` passes through two synchronizer flops. In bypass, a change driven before a rising edge appears on `level` after the third rising edge.
- R3: Latency codes other than 4'b0001, 4'b0010, 4'b0100 and 4'b1000 select bypass, including 4'b0000 and 4'b0011. In bypass, `level` follows the synchronized input every clock.
- R4: Codes 4'b0001, 4'b0010, 4'b0100 and 4'b1000 set a width W of 2, 4, 8 and 16. The synchronized input must differ from `level` on W+1 consecutive sampling edges before `level` takes the new value. With `fsel`=0, every clock is a sampling edge, so a 3-cycle pulse passes W=2 and a 2-cycle pulse does not.
- R5: With `fsel`=1, a sampling edge occurs once every (`gdiv`+1)·(`cdiv`+1) clocks when `cdiv_en`=1.
- R6: With `cdiv_en`=0, `cdiv` has no effect and the rate is one sampling edge per (`gdiv`+1) clocks.
- R7: A sampling edge that sees the synchronized input equal to `level` restarts the count. Two 4-cycle pulses separated by a 1-cycle gap never pass W=4.
- R8: With `edge_pol`=1, a 0→1 change of `level` sets `edge_flag`. With `edge_pol`=0, a 1→0 change sets it. The flag rises on the same clock edge as the change of `level`.
- R9: `edge_flag` stays set until a cycle with `flag_clr`=1. A new edge in the same cycle as `flag_clr` keeps the flag set.
- R10: With `gdiv`=7, `cdiv`=0, `cdiv_en`=1, `fsel`=1 and code 4'b1000, a 128-cycle pulse is blocked and a 136-cycle pulse passes, regardless of the divider phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Raw asynchronous input |
| gdiv | input | GW | Global divider value (divide by gdiv+1) |
| cdiv | input | CW | Channel divider value (divide by cdiv+1) |
| cdiv_en | input | 1 | Channel divider enable |
| fsel | input | 1 | 0: sample every clock, 1: sample on prescaled enables |
| lat_code | input | 4 | Minimum-width code |
| edge_pol | input | 1 | 1: flag rising edges, 0: flag falling edges |
| flag_clr | input | 1 | Clears edge_flag (write-one pulse) |
| level | output | 1 | Filtered input level |
| edge_flag | output | 1 | Sticky edge flag |

## Verification
The hardest cases to reach are pulses whose length sits one sampling period either side of the threshold. Whether such a pulse passes depends on where the free-running dividers are in their count when the pulse starts. The stimulus therefore uses pulse lengths that are multiples of the divider period, for which the outcome does not depend on phase. It repeats them at several start offsets, while a behavioural model tracking the divider phase is compared on every clock.

// File: rtl/glitch_filter.sv
module glitch_filter #(
  parameter int GW = 8,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_in,
  input  logic [GW-1:0] gdiv,
  input  logic [CW-1:0] cdiv,
  input  logic          cdiv_en,
  input  logic          fsel,
  input  logic [3:0]    lat_code,
  input  logic          edge_pol,
  input  logic          flag_clr,
  output logic          level,
  output logic          edge_flag
);
  localparam int NW = 5;

  logic          s1, s2;
  logic [GW-1:0] gcnt;
  logic [CW-1:0] ccnt;
  logic [NW-1:0] width, cnt;
  logic          gtick, cwrap, tick, bypass, lvl_nxt, ev;

  always_comb begin
    case (lat_code)
      4'b0001: width = NW'(2);
      4'b0010: width = NW'(4);
      4'b0100: width = NW'(8);
      4'b1000: width = NW'(16);
      default: width = '0;
    endcase
  end

  assign bypass = (width == '0);
  assign gtick  = (gcnt == gdiv);
  assign cwrap  = !cdiv_en || (ccnt == cdiv);
  assign tick   = fsel ? (gtick && cwrap) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      gcnt <= '0;
      ccnt <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      gcnt <= gtick ? '0 : gcnt + 1'b1;
      if (gtick) ccnt <= cwrap ? '0 : ccnt + 1'b1;
    end
  end

  assign lvl_nxt = bypass ? s2 :
                   (tick && s2 != level && cnt == width) ? s2 : level;
  assign ev = (lvl_nxt != level) && (lvl_nxt == edge_pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      level <= 1'b0;
      edge_flag <= 1'b0;
    end else begin
      if (bypass) cnt <= '0;
      else if (tick) begin
        if (s2 == level || cnt == width) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      level <= lvl_nxt;
      edge_flag <= ev | (edge_flag & ~flag_clr);
    end
  end

  assert_level_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level) |-> $past(bypass || tick));

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= NW'(16));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(edge_flag) |-> $past(flag_clr));

  assert_flag_pol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_flag) |-> (!$stable(level) && level == $past(edge_pol)));
endmodule

// File: tb/sim_glitch_filter.sv
`timescale 1ns/1ps
module sim_glitch_filter;
  logic clk = 1'b0, rst_n = 1'b0, pin_in = 1'b0;
  logic [7:0] gdiv = 8'd0;
  logic [1:0] cdiv = 2'd0;
  logic cdiv_en = 1'b0, fsel = 1'b0, edge_pol = 1'b1, flag_clr = 1'b0;
  logic [3:0] lat_code = 4'd0;
  logic level, edge_flag;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  glitch_filter #(.GW(8), .CW(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .gdiv(gdiv), .cdiv(cdiv),
    .cdiv_en(cdiv_en), .fsel(fsel), .lat_code(lat_code), .edge_pol(edge_pol),
    .flag_clr(flag_clr), .level(level), .edge_flag(edge_flag));

  int m_q[$];
  int gph, cph, run, m_lvl, m_flag;

  function automatic int wdec(input logic [3:0] c);
    if (c == 4'd1) return 2;
    if (c == 4'd2) return 4;
    if (c == 4'd4) return 8;
    if (c == 4'd8) return 16;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q = {0, 0}; gph = 0; cph = 0; run = 0; m_lvl = 0; m_flag = 0;
    end else begin
      int seen, w, samp, nl;
      bit g, c;
      seen = m_q[0];
      w = wdec(lat_code);
      g = (gph == gdiv);
      c = !cdiv_en || (cph == cdiv);
      samp = fsel ? (g && c) : 1;
      nl = m_lvl;
      if (w == 0) begin run = 0; nl = seen; end
      else if (samp) begin
        if (seen == m_lvl) run = 0;
        else begin
          run++;
          if (run == w + 1) begin nl = seen; run = 0; end
        end
      end
      if (nl != m_lvl && nl == edge_pol) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_lvl = nl;
      if (g) cph = c ? 0 : (cph + 1) % 4;
      gph = g ? 0 : (gph + 1) % 256;
      void'(m_q.pop_front());
      m_q.push_back(int'(pin_in));
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (level !== m_lvl[0] || edge_flag !== m_flag[0]) begin
      fails++;
      $display("FAIL R4 model: level=%0b flag=%0b expected level=%0d flag=%0d",
               level, edge_flag, m_lvl, m_flag);
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
  endtask

  task automatic pulse(input int len, input int settle);
    pin_in = 1'b1; step(len); pin_in = 1'b0; step(settle);
  endtask

  initial begin
    step(3);
    chk("R1 level in reset", level, 1'b0);
    chk("R1 flag in reset", edge_flag, 1'b0);
    rst_n = 1'b1;
    step(1);
    chk("R1 level after reset", level, 1'b0);
    chk("R1 flag after reset", edge_flag, 1'b0);

    lat_code = 4'b0000;
    pin_in = 1'b1; step(2);
    chk("R2 not yet after two edges", level, 1'b0);
    step(1);
    chk("R2 after third edge", level, 1'b1);
    chk("R8 rising sets flag", edge_flag, 1'b1);
    lat_code = 4'b0011;
    pin_in = 1'b0; step(3);
    chk("R3 code 0011 bypass", level, 1'b0);
    clr();
    chk("R9 cleared", edge_flag, 1'b0);

    lat_code = 4'b0001; fsel = 1'b0; step(5);
    pulse(2, 10);
    chk("R4 2-cycle blocked at W=2", edge_flag, 1'b0);
    pulse(3, 10);
    chk("R4 3-cycle passes at W=2", edge_flag, 1'b1);
    clr();

    lat_code = 4'b0010; step(5);
    pin_in = 1'b1; step(4); pin_in = 1'b0; step(1); pin_in = 1'b1; step(4);
    pin_in = 1'b0; step(12);
    chk("R7 gap restarts count", edge_flag, 1'b0);

    fsel = 1'b1; gdiv = 8'd3; cdiv = 2'd1; cdiv_en = 1'b1; lat_code = 4'b0001;
    step(20);
    for (int off = 0; off < 3; off++) begin
      step(off);
      pulse(16, 40);
      chk("R5 16 cycles blocked at 8-clock rate", edge_flag, 1'b0);
      pulse(24, 40);
      chk("R5 24 cycles pass at 8-clock rate", edge_flag, 1'b1);
      clr();
    end
    cdiv_en = 1'b0; step(20);
    for (int off = 0; off < 3; off++) begin
      step(off);
      pulse(12, 30);
      chk("R6 channel divider ignored when off", edge_flag, 1'b1);
      clr();
    end

    gdiv = 8'd7; cdiv = 2'd0; cdiv_en = 1'b1; lat_code = 4'b1000; step(20);
    for (int off = 0; off < 8; off += 3) begin
      step(off);
      pulse(128, 300);
      chk("R10 128 cycles blocked", edge_flag, 1'b0);
      pulse(136, 300);
      chk("R10 136 cycles pass", edge_flag, 1'b1);
      clr();
    end

    fsel = 1'b0; lat_code = 4'b0000; edge_pol = 1'b0; step(5);
    pin_in = 1'b1; step(5);
    chk("R8 rising ignored for falling polarity", edge_flag, 1'b0);
    pin_in = 1'b0; step(2);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R9 set wins over clear", edge_flag, 1'b1);
    step(5);
    chk("R9 flag sticky", edge_flag, 1'b1);
    clr();
    chk("R9 clear pulse", edge_flag, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule